// File: doc/BRIEF.md
# Cross-Correlation Islanding Trip Detector

This block decides whether a grid-tied inverter has lost its grid connection. A small harmonic at twice the mains frequency is injected by the inverter during periodic injection windows. While a window is open, the block multiplies each signed voltage sample taken at the common coupling point by a matching sample of a reference at twice the base frequency, and sums the products in a saturating accumulator. When the window is declared finished, the sum is frozen into a held correlation index. The window length is expected to span a whole number of fundamental periods, so that the index settles at its expected value.

Once per evaluation period, marked by a strobe, the held index is compared with a programmable signed threshold. The threshold is usually placed a fixed fraction (for example a quarter) of the way from the largest index seen on a healthy grid up to the smallest index seen when islanded. One over-threshold result is not enough: the block trips only after a parameterized number of consecutive over-threshold evaluations (two by default), and any evaluation at or below the threshold starts the run again. The trip output then stays asserted, holding the inverter off, until the block is reset.

Top module: `isl_trip_detect`

## Requirements
- R1: After reset the held index `cc_idx_o` is 0, `cc_vld_o` is 0 and `trip_o` is 0.
- R2: On each clock edge where `win_en_i` and `smp_vld_i` are both 1, the signed product `vpcc_i * vref_i` is added to the accumulator; samples with `smp_vld_i` at 0 or with `win_en_i` at 0 change nothing.
- R3: A window starts on the first cycle with `win_en_i` at 1 after a cycle with it at 0; the accumulator is cleared at that point, so the first accepted sample of a window is summed from zero and nothing from an earlier window carries over.
- R4: The accumulator saturates at +(2^(ACC_W-1)-1) and -2^(ACC_W-1) instead of wrapping.
- R5: A clock edge with `win_done_i` at 1 copies the accumulator as it stood before that edge into `cc_idx_o`, visible in the following cycle; at all other edges `cc_idx_o` keeps its value.
- R6: `cc_vld_o` is 1 for exactly the one cycle after each capture edge and 0 otherwise.
- R7: An edge with `eval_i` at 1 compares `cc_idx_o` with `thr_i` as signed numbers; strictly greater counts as an exceed, equal or lower clears the consecutive-exceed count to zero.
- R8: `trip_o` rises in the cycle after the edge holding the REP-th consecutive exceeding evaluation (REP = 2 by default), and never without an evaluation.
- R9: Once set, `trip_o` stays 1 through any later evaluations, captures and windows, and is cleared only by `rst_n`.
- R10: Edges without `eval_i` do not touch the consecutive-exceed count, so captures between two exceeding evaluations do not break the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also the only way to release a trip |
| win_en_i | input | 1 | Injection window open |
| smp_vld_i | input | 1 | Sample pair on `vpcc_i`/`vref_i` is valid this cycle |
| vpcc_i | input | SMP_W | Signed voltage sample at the coupling point |
| vref_i | input | SMP_W | Signed reference sample at twice the base frequency |
| win_done_i | input | 1 | Capture strobe: freeze the accumulator into the held index |
| eval_i | input | 1 | Evaluation strobe, once per evaluation period |
| thr_i | input | ACC_W | Signed trip threshold |
| cc_idx_o | output | ACC_W | Held signed correlation index |
| cc_vld_o | output | 1 | One-cycle strobe after each capture |
| trip_o | output | 1 | Latched islanding trip |

## Verification
A wrong accumulator shows at `cc_idx_o` in the cycle after the next capture strobe, so every window ends with a comparison of the held index against a sum computed in the bench, including windows that must clamp at either rail. A wrong exceed count or latch shows at `trip_o` one cycle after an evaluation strobe; every four-evaluation pattern of above/below results is replayed from reset, and each cycle's trip state is compared with a run-length model. Stickiness and reset release are checked right after the trip by further evaluations below the threshold and new captures.

// File: rtl/isl_trip_pkg.sv
`timescale 1ns/1ps
package isl_trip_pkg;

   // Result of one evaluation strobe.
   typedef enum logic [1:0] {
      EV_IDLE  = 2'd0,
      EV_BELOW = 2'd1,
      EV_ABOVE = 2'd2
   } ev_kind_e;

   // Bits needed to count from 0 up to n inclusive, at least one.
   function automatic int cnt_bits(input int n);
      int b;
      b = 1;
      while ((1 << b) <= n) b++;
      return b;
   endfunction

endpackage

// File: rtl/cc_mac.sv
`timescale 1ns/1ps
module cc_mac #(
   parameter int SMP_W = 12,
   parameter int ACC_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    win_en_i,
   input  logic                    smp_vld_i,
   input  logic signed [SMP_W-1:0] a_i,
   input  logic signed [SMP_W-1:0] b_i,
   output logic signed [ACC_W-1:0] acc_o
);
   localparam int PRD_W = 2 * SMP_W;
   localparam int SUM_W = ACC_W + 1;
   localparam logic signed [SUM_W-1:0] MAXV = {2'b00, {(ACC_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] MINV = {2'b11, {(ACC_W-1){1'b0}}};

   generate
      if (SMP_W < 2) begin : g_bad_smp
         $error("cc_mac: SMP_W must be at least 2");
      end
      if (ACC_W < PRD_W) begin : g_bad_acc
         $error("cc_mac: ACC_W must hold one full product");
      end
   endgenerate

   logic                    win_q;
   logic                    win_start;
   logic signed [PRD_W-1:0] prod;
   logic signed [SUM_W-1:0] base;
   logic signed [SUM_W-1:0] sum;
   logic signed [ACC_W-1:0] sat;
   logic signed [ACC_W-1:0] acc_q;

   assign win_start = win_en_i & ~win_q;

   always_comb begin
      prod = PRD_W'(a_i) * PRD_W'(b_i);
      base = win_start ? '0 : {acc_q[ACC_W-1], acc_q};
      sum  = base + {{(SUM_W-PRD_W){prod[PRD_W-1]}}, prod};
   end

   // Clamp the one-bit-wider sum back into the accumulator range.
   always_comb begin
      if (sum > MAXV)      sat = MAXV[ACC_W-1:0];
      else if (sum < MINV) sat = MINV[ACC_W-1:0];
      else                 sat = sum[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q <= 1'b0;
         acc_q <= '0;
      end else begin
         win_q <= win_en_i;
         if (win_en_i) begin
            if (smp_vld_i)      acc_q <= sat;
            else if (win_start) acc_q <= '0;
         end
      end
   end

   assign acc_o = acc_q;

   // R4
   acc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_en_i && smp_vld_i && !win_start && !acc_q[ACC_W-1] && !prod[PRD_W-1])
      |=> (!acc_q[ACC_W-1] && acc_q >= $past(acc_q)));

   // R3
   win_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_start && !smp_vld_i) |=> (acc_q == '0));

   // R2
   acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_en_i || (!smp_vld_i && win_q)) |=> $stable(acc_q));

endmodule

// File: rtl/cc_hold.sv
`timescale 1ns/1ps
module cc_hold #(
   parameter int ACC_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap_i,
   input  logic signed [ACC_W-1:0] acc_i,
   output logic signed [ACC_W-1:0] idx_o,
   output logic                    vld_o
);
   generate
      if (ACC_W < 4) begin : g_bad_w
         $error("cc_hold: ACC_W too small");
      end
   endgenerate

   logic signed [ACC_W-1:0] idx_q;
   logic                    vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= cap_i;
         if (cap_i) idx_q <= acc_i;
      end
   end

   assign idx_o = idx_q;
   assign vld_o = vld_q;

   // R6
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> vld_o);

   // R6
   vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i |=> !vld_o);

   // R5
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i |=> $stable(idx_o));

endmodule

// File: rtl/cc_trip_seq.sv
`timescale 1ns/1ps
module cc_trip_seq
   import isl_trip_pkg::*;
#(
   parameter int ACC_W = 24,
   parameter int REP   = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    eval_i,
   input  logic signed [ACC_W-1:0] idx_i,
   input  logic signed [ACC_W-1:0] thr_i,
   output logic                    trip_o
);
   localparam int CNT_W = cnt_bits(REP);

   generate
      if (REP < 1) begin : g_bad_rep
         $error("cc_trip_seq: REP must be at least 1");
      end
   endgenerate

   ev_kind_e ev;
   logic     hit;      // this evaluation completes the run
   logic     trip_q;

   always_comb begin
      if (!eval_i)             ev = EV_IDLE;
      else if (idx_i > thr_i)  ev = EV_ABOVE;
      else                     ev = EV_BELOW;
   end

   generate
      if (REP == 1) begin : g_single
         // A single exceed is enough: no run counter.
         assign hit = (ev == EV_ABOVE);
      end else begin : g_run
         logic [CNT_W-1:0] cnt_q;

         assign hit = (ev == EV_ABOVE) && (cnt_q >= CNT_W'(REP - 1));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else begin
               case (ev)
                  EV_ABOVE: if (cnt_q != CNT_W'(REP)) cnt_q <= cnt_q + 1'b1;
                  EV_BELOW: cnt_q <= '0;
                  default:  cnt_q <= cnt_q;
               endcase
            end
         end

         // R7
         cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev == EV_BELOW) |=> (cnt_q == '0));

         // R10
         cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev == EV_IDLE) |=> $stable(cnt_q));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   trip_q <= 1'b0;
      else if (hit) trip_q <= 1'b1;
   end

   assign trip_o = trip_q;

   // R9
   trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip_o |=> trip_o);

   // R8
   trip_on_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!eval_i && !trip_o) |=> !trip_o);

endmodule

// File: rtl/isl_trip_detect.sv
`timescale 1ns/1ps
module isl_trip_detect #(
   parameter int SMP_W = 12,
   parameter int ACC_W = 24,
   parameter int REP   = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    win_en_i,
   input  logic                    smp_vld_i,
   input  logic signed [SMP_W-1:0] vpcc_i,
   input  logic signed [SMP_W-1:0] vref_i,
   input  logic                    win_done_i,
   input  logic                    eval_i,
   input  logic signed [ACC_W-1:0] thr_i,
   output logic signed [ACC_W-1:0] cc_idx_o,
   output logic                    cc_vld_o,
   output logic                    trip_o
);
   logic signed [ACC_W-1:0] acc;

   cc_mac #(
      .SMP_W (SMP_W),
      .ACC_W (ACC_W)
   ) i_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_en_i  (win_en_i),
      .smp_vld_i (smp_vld_i),
      .a_i       (vpcc_i),
      .b_i       (vref_i),
      .acc_o     (acc)
   );

   cc_hold #(
      .ACC_W (ACC_W)
   ) i_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .cap_i (win_done_i),
      .acc_i (acc),
      .idx_o (cc_idx_o),
      .vld_o (cc_vld_o)
   );

   cc_trip_seq #(
      .ACC_W (ACC_W),
      .REP   (REP)
   ) i_trip (
      .clk    (clk),
      .rst_n  (rst_n),
      .eval_i (eval_i),
      .idx_i  (cc_idx_o),
      .thr_i  (thr_i),
      .trip_o (trip_o)
   );

   // R5
   idx_follows_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_done_i |=> (cc_idx_o == $past(acc)));

endmodule

// File: tb/test_isl_trip_detect.sv
`timescale 1ns/1ps
module test_isl_trip_detect;
   localparam int SMP_W = 12;
   localparam int ACC_W = 24;
   localparam int REP   = 2;
   localparam longint AMAX = (64'sd1 <<< (ACC_W-1)) - 1;
   localparam longint AMIN = -(64'sd1 <<< (ACC_W-1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic win_en = 1'b0, smp_vld = 1'b0, win_done = 1'b0, eval = 1'b0;
   logic signed [SMP_W-1:0] vpcc = '0, vref = '0;
   logic signed [ACC_W-1:0] thr = '0;
   logic signed [ACC_W-1:0] cc_idx;
   logic cc_vld, trip;

   int n_tests = 0, n_fail = 0;
   bit finished = 0;

   // bench model state
   longint m_acc, m_idx;
   bit     m_winq, m_vld, m_trip;
   int     m_cnt;

   always #2.5 clk = ~clk;

   isl_trip_detect #(.SMP_W(SMP_W), .ACC_W(ACC_W), .REP(REP)) i_isl_trip_detect (
      .clk(clk), .rst_n(rst_n), .win_en_i(win_en), .smp_vld_i(smp_vld),
      .vpcc_i(vpcc), .vref_i(vref), .win_done_i(win_done), .eval_i(eval),
      .thr_i(thr), .cc_idx_o(cc_idx), .cc_vld_o(cc_vld), .trip_o(trip));

   function automatic longint clamp(input longint v);
      if (v > AMAX) return AMAX;
      if (v < AMIN) return AMIN;
      return v;
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One clock: drive at a falling edge, model the rising edge, compare at the next falling edge.
   task automatic cyc(input bit w, input bit v, input int a, input int b,
                      input bit d, input bit e);
      bit st;
      win_en = w; smp_vld = v; vpcc = SMP_W'(a); vref = SMP_W'(b);
      win_done = d; eval = e;
      if (e) begin
         if (m_idx > longint'(thr)) begin
            if (m_cnt + 1 >= REP) m_trip = 1;
            if (m_cnt < REP) m_cnt++;
         end else m_cnt = 0;
      end
      m_vld = d;
      if (d) m_idx = m_acc;
      st = w && !m_winq;
      if (w) begin
         if (v) m_acc = clamp((st ? 0 : m_acc) + longint'(a) * longint'(b));
         else if (st) m_acc = 0;
      end
      m_winq = w;
      @(negedge clk);
      chk("R5 held index", longint'(cc_idx), m_idx);
      chk("R6 valid strobe", longint'(cc_vld), longint'(m_vld));
      chk("R8 trip state", longint'(trip), longint'(m_trip));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      win_en = 0; smp_vld = 0; win_done = 0; eval = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_acc = 0; m_idx = 0; m_winq = 0; m_vld = 0; m_trip = 0; m_cnt = 0;
   endtask

   // Load a single-product index a*b into the held register.
   task automatic load_idx(input int a, input int b);
      cyc(1, 1, a, b, 0, 0);
      cyc(0, 0, 0, 0, 1, 0);
      cyc(0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1: reset state
      chk("R1 idx after reset", longint'(cc_idx), 0);
      chk("R1 vld after reset", longint'(cc_vld), 0);
      chk("R1 trip after reset", longint'(trip), 0);

      // R2/R3: sweep of windows with gaps and stray samples outside the window
      for (int w = 0; w < 8; w++) begin
         longint esum = 0;
         cyc(0, 1, 1500, 1500, 0, 0);          // ignored: window closed
         for (int i = 0; i < 6 + w; i++) begin
            int a = ((i * 389 + w * 97) % 4096) - 2048;
            int b = ((i * 211 + w * 53 + 700) % 4096) - 2048;
            bit v = ((i + w) % 3) != 2;
            if (v) esum = clamp(esum + longint'(a) * longint'(b));
            cyc(1, v, a, b, 0, 0);
         end
         cyc(0, 1, -900, 1200, 0, 0);          // ignored: window closed
         cyc(0, 0, 0, 0, 1, 0);
         chk("R2 window sum", longint'(cc_idx), esum);
         chk("R3 fresh window", longint'(cc_idx), esum);
         idle(1);
      end

      // R4: saturation at both rails
      for (int i = 0; i < 3; i++) cyc(1, 1, 2047, 2047, 0, 0);
      cyc(0, 0, 0, 0, 1, 0);
      chk("R4 positive rail", longint'(cc_idx), AMAX);
      for (int i = 0; i < 3; i++) cyc(1, 1, 2047, -2048, 0, 0);
      cyc(0, 0, 0, 0, 1, 0);
      chk("R4 negative rail", longint'(cc_idx), AMIN);
      cyc(1, 1, -2048, -2048, 0, 0);
      cyc(1, 1, -2048, -2048, 0, 0);
      cyc(0, 0, 0, 0, 1, 0);
      chk("R4 exact overflow by one", longint'(cc_idx), AMAX);
      idle(1);
      chk("R6 strobe single cycle", longint'(cc_vld), 0);

      // R7/R8: every above/below pattern of four evaluations, index 1000
      for (int pat = 0; pat < 16; pat++) begin
         int run = 0;
         bit exp_trip = 0;
         do_reset();
         load_idx(100, 10);
         for (int k = 0; k < 4; k++) begin
            bit above = pat[k];
            thr = above ? ACC_W'(999) : ACC_W'(1000);   // equal is not an exceed
            cyc(0, 0, 0, 0, 0, 1);
            run = above ? run + 1 : 0;
            if (run >= REP) exp_trip = 1;
            chk("R7/R8 consecutive run", longint'(trip), longint'(exp_trip));
            idle(1);
         end
         if (exp_trip) begin
            thr = ACC_W'(5000);
            cyc(0, 0, 0, 0, 0, 1);
            load_idx(0, 0);
            cyc(0, 0, 0, 0, 0, 1);
            chk("R9 trip stays latched", longint'(trip), 1);
         end
      end

      // R9: reset is the only release
      do_reset();
      chk("R9 reset releases trip", longint'(trip), 0);

      // R7: signed comparison with negative index and threshold
      load_idx(-50, 10);
      thr = -ACC_W'(501);
      cyc(0, 0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 0, 1);
      chk("R7 signed exceed trips", longint'(trip), 1);

      // R10: a capture between two exceeds keeps the run
      do_reset();
      load_idx(30, 30);
      thr = ACC_W'(800);
      cyc(0, 0, 0, 0, 0, 1);
      chk("R10 one exceed no trip", longint'(trip), 0);
      load_idx(40, 40);
      idle(2);
      chk("R10 capture no trip", longint'(trip), 0);
      cyc(0, 0, 0, 0, 0, 1);
      chk("R10 run survives capture", longint'(trip), 1);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule